// File: doc/BRIEF.md
# Configurable UART Transmitter with Flow Gating

This block turns bytes offered on a ready/valid input into asynchronous serial frames on a single TXD line. The line is high when idle. A frame is one low start bit, then the data bits with the least-significant bit first, then an optional parity bit, then one or more high stop bits. Software sets the character format, the bit-rate divider and a line-break command through a small write-only register port. A byte that has been accepted waits in a one-byte holding register until flow control allows it to start.

Flow control works in one of two ways. In hardware mode a new character starts only while the active-low clear-to-send input is asserted. In software mode the receive side reports each received byte as a one-cycle strobe. The pause code stops new characters and the resume code lets them start again. A character that has already started always runs to its end. The break command drives the line low for as long as it is set, and it begins only after the current character has finished.

Top module: `uart_tx_engine`

## Requirements
- R1: After reset, txd is 1 and in_ready is 1.
- R2: A frame is a start bit of 0, then the data bits LSB first, then the parity bit if enabled, then stop bits of 1. Each bit lasts 16*(D+1) clock cycles, where D is the divider value written at address 1.
- R3: Format bits [1:0] at address 0 select the data length: code c sends 5+c bits.
- R4: Format bits [4:2] select the parity. Code 0 means no parity bit. Code 1 is odd, code 2 is even, code 3 always sends 1 and code 4 always sends 0. Odd and even parity cover only the configured data bits.
- R5: Format bits [6:5] select the stop length. Code 0 gives 16 ticks, code 1 gives 24 ticks and code 2 gives 32 ticks. in_ready returns to 1 in the first cycle after the last stop tick.
- R6: The bit time scales with the divider value D. The divider is sampled when a character starts.
- R7: Writing 1 to bit 0 at address 2 holds txd at 0 after any character in progress has finished, and in_ready stays 0 for that whole time. Writing 0 returns the line to 1 and in_ready to 1.
- R8: With format bits [8:7] = 1, a character starts only while cts_n is 0. A character that has already started is not cut short when cts_n rises.
- R9: With format bits [8:7] = 2, a received code 0x13 blocks new starts and a received code 0x11 allows them again. Other codes have no effect. Outside this mode the pause state does not gate transmission.
- R10: A write to the format or divider register during a character does not change that character. The new value applies from the next character.
- R11: in_ready goes to 0 in the cycle after a byte is accepted and stays 0 until the last stop bit ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 2 | Register address: 0 = format, 1 = divider, 2 = break control |
| cfg_wdata | input | DIV_W | Register write data |
| in_valid | input | 1 | A byte is offered |
| in_data | input | 8 | Offered byte |
| in_ready | output | 1 | The block can accept a byte |
| cts_n | input | 1 | Clear-to-send, active low, asynchronous |
| rx_valid | input | 1 | One-cycle strobe for a received byte |
| rx_data | input | 8 | Received byte, checked for the pause and resume codes |
| txd | output | 1 | Serial output, idles high |

## Verification
A wrong bit counter or tick counter moves the point where in_ready rises, or shifts a sampled data, parity or stop level. The bench measures both to the exact cycle, counted from the falling edge of the start bit. A wrong snapshot of the format or divider shows within the same character, as a frame of the wrong length. A flow or break state that is not set or not cleared shows as a start bit that appears early, or as a line that stays quiet for hundreds of cycles. Sweeping every length, parity and stop code brings any wrong parity mask or stop length out at the ports within one frame.

// File: rtl/uart_tx_pkg.sv
`timescale 1ns/1ps
package uart_tx_pkg;

    localparam logic [1:0] ADDR_FMT  = 2'd0;
    localparam logic [1:0] ADDR_DIV  = 2'd1;
    localparam logic [1:0] ADDR_CTRL = 2'd2;

    typedef enum logic [2:0] {
        PAR_NONE  = 3'd0,
        PAR_ODD   = 3'd1,
        PAR_EVEN  = 3'd2,
        PAR_MARK  = 3'd3,
        PAR_SPACE = 3'd4
    } par_e;

    typedef enum logic [1:0] {
        STOP_ONE      = 2'd0,
        STOP_ONE_HALF = 2'd1,
        STOP_TWO      = 2'd2
    } stop_e;

    typedef enum logic [1:0] {
        FLOW_OFF     = 2'd0,
        FLOW_CTS     = 2'd1,
        FLOW_XONXOFF = 2'd2
    } flow_e;

    typedef struct packed {
        logic [1:0] len_code;
        par_e       par;
        stop_e      stop;
        flow_e      flow;
    } fmt_t;

    typedef enum logic [2:0] {
        S_IDLE   = 3'd0,
        S_START  = 3'd1,
        S_DATA   = 3'd2,
        S_PARITY = 3'd3,
        S_STOP   = 3'd4,
        S_BREAK  = 3'd5
    } tx_state_e;

endpackage

// File: rtl/uart_tx_cfg.sv
`timescale 1ns/1ps
module uart_tx_cfg
    import uart_tx_pkg::*;
#(
    parameter int unsigned   DIV_W     = 16,
    parameter logic [DIV_W-1:0] DIV_RESET = DIV_W'(25)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_we,
    input  logic [1:0]       cfg_addr,
    input  logic [DIV_W-1:0] cfg_wdata,
    output fmt_t             fmt,
    output logic [DIV_W-1:0] div,
    output logic             brk
);

    typedef struct packed {
        fmt_t             fmt;
        logic [DIV_W-1:0] div;
        logic             brk;
    } cfg_t;

    cfg_t cfg_d, cfg_q;

    function automatic par_e dec_par(logic [2:0] code);
        case (code)
            3'd1:    return PAR_ODD;
            3'd2:    return PAR_EVEN;
            3'd3:    return PAR_MARK;
            3'd4:    return PAR_SPACE;
            default: return PAR_NONE;
        endcase
    endfunction

    function automatic stop_e dec_stop(logic [1:0] code);
        case (code)
            2'd0:    return STOP_ONE;
            2'd1:    return STOP_ONE_HALF;
            default: return STOP_TWO;
        endcase
    endfunction

    function automatic flow_e dec_flow(logic [1:0] code);
        case (code)
            2'd1:    return FLOW_CTS;
            2'd2:    return FLOW_XONXOFF;
            default: return FLOW_OFF;
        endcase
    endfunction

    always_comb begin
        cfg_d = cfg_q;
        if (cfg_we) begin
            case (cfg_addr)
                ADDR_FMT: begin
                    cfg_d.fmt.len_code = cfg_wdata[1:0];
                    cfg_d.fmt.par      = dec_par(cfg_wdata[4:2]);
                    cfg_d.fmt.stop     = dec_stop(cfg_wdata[6:5]);
                    cfg_d.fmt.flow     = dec_flow(cfg_wdata[8:7]);
                end
                ADDR_DIV:  cfg_d.div = cfg_wdata;
                ADDR_CTRL: cfg_d.brk = cfg_wdata[0];
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q              <= '0;
            cfg_q.fmt.len_code <= 2'd3;
            cfg_q.div          <= DIV_RESET;
        end else begin
            cfg_q <= cfg_d;
        end
    end

    assign fmt = cfg_q.fmt;
    assign div = cfg_q.div;
    assign brk = cfg_q.brk;

endmodule

// File: rtl/uart_tx_baud.sv
`timescale 1ns/1ps
module uart_tx_baud #(
    parameter int unsigned DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart,
    input  logic [DIV_W-1:0] div_in,
    output logic             tick
);

    typedef struct packed {
        logic [DIV_W-1:0] cnt;
        logic [DIV_W-1:0] div;
    } baud_t;

    baud_t baud_d, baud_q;

    always_comb begin
        baud_d = baud_q;
        if (restart) begin
            baud_d.cnt = '0;
            baud_d.div = div_in;
        end else if (baud_q.cnt == baud_q.div) begin
            baud_d.cnt = '0;
        end else begin
            baud_d.cnt = baud_q.cnt + DIV_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) baud_q <= '0;
        else        baud_q <= baud_d;
    end

    assign tick = (baud_q.cnt == baud_q.div);

endmodule

// File: rtl/uart_tx_flow.sv
`timescale 1ns/1ps
module uart_tx_flow
    import uart_tx_pkg::*;
#(
    parameter int unsigned SYNC_N    = 2,
    parameter logic [7:0]  XON_CODE  = 8'h11,
    parameter logic [7:0]  XOFF_CODE = 8'h13
) (
    input  logic       clk,
    input  logic       rst_n,
    input  flow_e      mode,
    input  logic       cts_n,
    input  logic       rx_valid,
    input  logic [7:0] rx_data,
    output logic       go
);

    typedef struct packed {
        logic [SYNC_N-1:0] sync;
        logic              paused;
    } flow_t;

    flow_t flow_d, flow_q;

    always_comb begin
        flow_d      = flow_q;
        flow_d.sync = {flow_q.sync[SYNC_N-2:0], cts_n};
        if (rx_valid) begin
            if (rx_data == XOFF_CODE)     flow_d.paused = 1'b1;
            else if (rx_data == XON_CODE) flow_d.paused = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flow_q.sync   <= '1;
            flow_q.paused <= 1'b0;
        end else begin
            flow_q <= flow_d;
        end
    end

    always_comb begin
        case (mode)
            FLOW_CTS:     go = ~flow_q.sync[SYNC_N-1];
            FLOW_XONXOFF: go = ~flow_q.paused;
            default:      go = 1'b1;
        endcase
    end

endmodule

// File: rtl/uart_tx_core.sv
`timescale 1ns/1ps
module uart_tx_core
    import uart_tx_pkg::*;
#(
    parameter int unsigned OVS = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick,
    input  logic [1:0] len_code,
    input  par_e       par_mode,
    input  stop_e      stop_mode,
    input  logic       brk,
    input  logic       go,
    input  logic       in_valid,
    input  logic [7:0] in_data,
    output logic       in_ready,
    output logic       txd,
    output logic       frame_start,
    output logic       tx_active,
    output logic       in_break
);

    localparam int unsigned SUB_W = $clog2(2 * OVS);
    localparam logic [SUB_W-1:0] BIT_LAST = SUB_W'(OVS - 1);

    typedef struct packed {
        tx_state_e        state;
        logic             full;
        logic [7:0]       hold;
        logic [7:0]       shreg;
        logic [3:0]       nbits;
        logic [2:0]       bidx;
        logic [SUB_W-1:0] sub;
        par_e             par;
        stop_e            stop;
        logic             pbit;
        logic             txd;
    } core_t;

    core_t core_d, core_q;
    logic  bit_last;

    function automatic logic [SUB_W-1:0] stop_last(stop_e s);
        case (s)
            STOP_ONE:      return SUB_W'(OVS - 1);
            STOP_ONE_HALF: return SUB_W'(OVS + OVS / 2 - 1);
            default:       return SUB_W'(2 * OVS - 1);
        endcase
    endfunction

    function automatic logic par_of(logic [7:0] v, logic [1:0] lc, par_e m);
        logic [7:0] mask;
        logic       ones;
        mask = 8'hFF >> (3'd3 - {1'b0, lc});
        ones = ^(v & mask);
        case (m)
            PAR_ODD:  return ~ones;
            PAR_EVEN: return ones;
            PAR_MARK: return 1'b1;
            default:  return 1'b0;
        endcase
    endfunction

    assign in_ready = (core_q.state == S_IDLE) && !core_q.full && !brk;

    always_comb begin
        core_d      = core_q;
        frame_start = 1'b0;
        bit_last    = (core_q.sub == BIT_LAST);

        if (in_valid && in_ready) begin
            core_d.full = 1'b1;
            core_d.hold = in_data;
        end

        case (core_q.state)
            S_IDLE: begin
                if (brk) begin
                    core_d.state = S_BREAK;
                    core_d.txd   = 1'b0;
                end else if (core_q.full && go) begin
                    core_d.state = S_START;
                    core_d.txd   = 1'b0;
                    core_d.sub   = '0;
                    core_d.nbits = 4'd5 + {2'b00, len_code};
                    core_d.par   = par_mode;
                    core_d.stop  = stop_mode;
                    core_d.shreg = core_q.hold;
                    core_d.pbit  = par_of(core_q.hold, len_code, par_mode);
                    frame_start  = 1'b1;
                end
            end
            S_START: begin
                if (tick) begin
                    if (bit_last) begin
                        core_d.sub   = '0;
                        core_d.state = S_DATA;
                        core_d.bidx  = '0;
                        core_d.txd   = core_q.shreg[0];
                    end else begin
                        core_d.sub = core_q.sub + SUB_W'(1);
                    end
                end
            end
            S_DATA: begin
                if (tick) begin
                    if (bit_last) begin
                        core_d.sub = '0;
                        if ({1'b0, core_q.bidx} == core_q.nbits - 4'd1) begin
                            if (core_q.par != PAR_NONE) begin
                                core_d.state = S_PARITY;
                                core_d.txd   = core_q.pbit;
                            end else begin
                                core_d.state = S_STOP;
                                core_d.txd   = 1'b1;
                            end
                        end else begin
                            core_d.bidx  = core_q.bidx + 3'd1;
                            core_d.shreg = {1'b0, core_q.shreg[7:1]};
                            core_d.txd   = core_q.shreg[1];
                        end
                    end else begin
                        core_d.sub = core_q.sub + SUB_W'(1);
                    end
                end
            end
            S_PARITY: begin
                if (tick) begin
                    if (bit_last) begin
                        core_d.sub   = '0;
                        core_d.state = S_STOP;
                        core_d.txd   = 1'b1;
                    end else begin
                        core_d.sub = core_q.sub + SUB_W'(1);
                    end
                end
            end
            S_STOP: begin
                if (tick) begin
                    if (core_q.sub == stop_last(core_q.stop)) begin
                        core_d.sub   = '0;
                        core_d.state = S_IDLE;
                        core_d.full  = 1'b0;
                        core_d.txd   = 1'b1;
                    end else begin
                        core_d.sub = core_q.sub + SUB_W'(1);
                    end
                end
            end
            S_BREAK: begin
                core_d.txd = 1'b0;
                if (!brk) begin
                    core_d.state = S_IDLE;
                    core_d.txd   = 1'b1;
                end
            end
            default: begin
                core_d.state = S_IDLE;
                core_d.txd   = 1'b1;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            core_q     <= '0;
            core_q.txd <= 1'b1;
        end else begin
            core_q <= core_d;
        end
    end

    assign txd       = core_q.txd;
    assign tx_active = (core_q.state == S_START) || (core_q.state == S_DATA) ||
                       (core_q.state == S_PARITY) || (core_q.state == S_STOP);
    assign in_break  = (core_q.state == S_BREAK);

endmodule

// File: rtl/uart_tx_engine.sv
`timescale 1ns/1ps
module uart_tx_engine
    import uart_tx_pkg::*;
#(
    parameter int unsigned      DIV_W     = 16,
    parameter logic [DIV_W-1:0] DIV_RESET = DIV_W'(25),
    parameter int unsigned      OVS       = 16,
    parameter int unsigned      SYNC_N    = 2,
    parameter logic [7:0]       XON_CODE  = 8'h11,
    parameter logic [7:0]       XOFF_CODE = 8'h13
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_we,
    input  logic [1:0]       cfg_addr,
    input  logic [DIV_W-1:0] cfg_wdata,
    input  logic             in_valid,
    input  logic [7:0]       in_data,
    output logic             in_ready,
    input  logic             cts_n,
    input  logic             rx_valid,
    input  logic [7:0]       rx_data,
    output logic             txd
);

    fmt_t             fmt;
    logic [DIV_W-1:0] div;
    logic             brk_on;
    logic             flow_go;
    logic             tick;
    logic             frame_start;
    logic             tx_active;
    logic             in_break;

    uart_tx_cfg #(
        .DIV_W     (DIV_W),
        .DIV_RESET (DIV_RESET)
    ) u_cfg (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_we    (cfg_we),
        .cfg_addr  (cfg_addr),
        .cfg_wdata (cfg_wdata),
        .fmt       (fmt),
        .div       (div),
        .brk       (brk_on)
    );

    uart_tx_baud #(
        .DIV_W (DIV_W)
    ) u_baud (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (frame_start),
        .div_in  (div),
        .tick    (tick)
    );

    uart_tx_flow #(
        .SYNC_N    (SYNC_N),
        .XON_CODE  (XON_CODE),
        .XOFF_CODE (XOFF_CODE)
    ) u_flow (
        .clk      (clk),
        .rst_n    (rst_n),
        .mode     (fmt.flow),
        .cts_n    (cts_n),
        .rx_valid (rx_valid),
        .rx_data  (rx_data),
        .go       (flow_go)
    );

    uart_tx_core #(
        .OVS (OVS)
    ) u_core (
        .clk         (clk),
        .rst_n       (rst_n),
        .tick        (tick),
        .len_code    (fmt.len_code),
        .par_mode    (fmt.par),
        .stop_mode   (fmt.stop),
        .brk         (brk_on),
        .go          (flow_go),
        .in_valid    (in_valid),
        .in_data     (in_data),
        .in_ready    (in_ready),
        .txd         (txd),
        .frame_start (frame_start),
        .tx_active   (tx_active),
        .in_break    (in_break)
    );

endmodule

// File: rtl/uart_tx_engine_chk.sv
`timescale 1ns/1ps
module uart_tx_engine_chk (
    input logic clk,
    input logic rst_n,
    input logic in_valid,
    input logic in_ready,
    input logic txd,
    input logic tx_active,
    input logic in_break,
    input logic frame_start,
    input logic flow_go,
    input logic brk_on
);

    AST_START_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start |-> (flow_go && !brk_on)); // R8

    AST_START_BIT_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start |=> !txd); // R2

    AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
        tx_active |-> !in_ready); // R11

    AST_ACCEPT_CLOSES: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |=> !in_ready); // R11

    AST_BREAK_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
        brk_on |-> !in_ready); // R7

    AST_BREAK_AFTER_CHAR: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(in_break) |-> !$past(tx_active)); // R7

    AST_BREAK_LINE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        in_break |-> !txd); // R7

endmodule

bind uart_tx_engine uart_tx_engine_chk i_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .in_valid    (in_valid),
    .in_ready    (in_ready),
    .txd         (txd),
    .tx_active   (tx_active),
    .in_break    (in_break),
    .frame_start (frame_start),
    .flow_go     (flow_go),
    .brk_on      (brk_on)
);

// File: tb/test_uart_tx_engine.sv
`timescale 1ns/1ps
module test_uart_tx_engine;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        cfg_we;
    logic [1:0]  cfg_addr;
    logic [15:0] cfg_wdata;
    logic        in_valid;
    logic [7:0]  in_data;
    logic        in_ready;
    logic        cts_n;
    logic        rx_valid;
    logic [7:0]  rx_data;
    logic        txd;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    uart_tx_engine i_uart_tx_engine (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_we    (cfg_we),
        .cfg_addr  (cfg_addr),
        .cfg_wdata (cfg_wdata),
        .in_valid  (in_valid),
        .in_data   (in_data),
        .in_ready  (in_ready),
        .cts_n     (cts_n),
        .rx_valid  (rx_valid),
        .rx_data   (rx_data),
        .txd       (txd)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic logic [15:0] fmtw(int len, int par, int stp, int flow);
        return 16'((flow << 7) | (stp << 5) | (par << 2) | len);
    endfunction

    task automatic cfg_write(input logic [1:0] a, input logic [15:0] v);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = v;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic put_byte(input logic [7:0] d);
        int g = 0;
        @(negedge clk);
        while (!in_ready && g < 5000) begin
            @(negedge clk);
            g++;
        end
        if (g >= 5000) chk(1'b0, "R11 accept timeout", 0, 1);
        in_valid = 1'b1; in_data = d;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic rx_pulse(input logic [7:0] code);
        @(negedge clk);
        rx_valid = 1'b1; rx_data = code;
        @(negedge clk);
        rx_valid = 1'b0;
    endtask

    task automatic wait_low();
        @(negedge clk);
        while (txd !== 1'b0) @(negedge clk);
    endtask

    task automatic hold_idle(input int n, input string req);
        int bad = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (txd !== 1'b1) bad++;
        end
        chk(bad == 0, req, bad, 0);
    endtask

    // Waits for a start bit and checks every bit at its centre.
    task automatic expect_frame(input logic [7:0] d, input int n, input int par,
                                input int stp, input int bt, input bit chk_end,
                                input string req);
        int g = 0;
        int c;
        int pp;
        int ones;
        int pexp;
        int tot;
        @(negedge clk);
        while (txd !== 1'b0 && g < 4000) begin
            @(negedge clk);
            g++;
        end
        if (g >= 4000) begin
            chk(1'b0, "R2 no start bit", 1, 0);
            return;
        end
        c = 0;
        repeat (bt / 2) @(negedge clk);
        c += bt / 2;
        chk(txd === 1'b0, "R2 start level", int'(txd), 0);
        chk(in_ready === 1'b0, "R11 busy", int'(in_ready), 0);
        for (int i = 0; i < n; i++) begin
            repeat (bt) @(negedge clk);
            c += bt;
            chk(txd === d[i], {req, " data bit"}, int'(txd), int'(d[i]));
        end
        pp = (par != 0) ? 1 : 0;
        if (pp == 1) begin
            ones = $countones(d & 8'((1 << n) - 1)) % 2;
            case (par)
                1: pexp = 1 - ones;
                2: pexp = ones;
                3: pexp = 1;
                default: pexp = 0;
            endcase
            repeat (bt) @(negedge clk);
            c += bt;
            chk(txd === 1'(pexp), "R4 parity", int'(txd), pexp);
        end
        repeat (bt) @(negedge clk);
        c += bt;
        chk(txd === 1'b1, "R5 stop level", int'(txd), 1);
        if (chk_end) begin
            tot = (1 + n + pp) * bt + (16 + 8 * stp) * (bt / 16);
            while (!in_ready && c < tot + 64) begin
                @(negedge clk);
                c++;
            end
            chk(c == tot, "R5 frame end", c, tot);
        end
    endtask

    initial begin
        repeat (180000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        rst_n = 1'b0; cfg_we = 1'b0; cfg_addr = '0; cfg_wdata = '0;
        in_valid = 1'b0; in_data = '0; cts_n = 1'b0; rx_valid = 1'b0; rx_data = '0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(txd === 1'b1, "R1 txd", int'(txd), 1);
        chk(in_ready === 1'b1, "R1 in_ready", int'(in_ready), 1);

        // R3 R4 R5: every length, parity and stop code at the fastest rate
        cfg_write(2'd1, 16'd0);
        for (int l = 0; l < 4; l++)
            for (int p = 0; p < 5; p++)
                for (int s = 0; s < 3; s++) begin
                    logic [7:0] dat;
                    dat = 8'(8'h5A + l * 53 + p * 17 + s * 91);
                    cfg_write(2'd0, fmtw(l, p, s, 0));
                    put_byte(dat);
                    expect_frame(dat, 5 + l, p, s, 16, 1'b1, "R3");
                end

        // R6: slower divider values
        cfg_write(2'd1, 16'd3);
        cfg_write(2'd0, fmtw(3, 2, 0, 0));
        put_byte(8'hC3);
        expect_frame(8'hC3, 8, 2, 0, 64, 1'b1, "R6");
        cfg_write(2'd1, 16'd9);
        cfg_write(2'd0, fmtw(2, 1, 2, 0));
        put_byte(8'h3C);
        expect_frame(8'h3C, 7, 1, 2, 160, 1'b1, "R6");

        // R10: writes during a character apply to the next one
        cfg_write(2'd1, 16'd0);
        cfg_write(2'd0, fmtw(3, 0, 0, 0));
        put_byte(8'hB7);
        fork
            expect_frame(8'hB7, 8, 0, 0, 16, 1'b1, "R10");
            begin
                wait_low();
                repeat (40) @(negedge clk);
                cfg_write(2'd0, fmtw(0, 1, 2, 0));
                cfg_write(2'd1, 16'd1);
            end
        join
        put_byte(8'h6E);
        expect_frame(8'h6E, 5, 1, 2, 32, 1'b1, "R10");

        // R8: hardware handshake
        cfg_write(2'd1, 16'd0);
        cfg_write(2'd0, fmtw(3, 0, 0, 1));
        cts_n = 1'b1;
        repeat (4) @(negedge clk);
        put_byte(8'h81);
        hold_idle(300, "R8 gated");
        cts_n = 1'b0;
        expect_frame(8'h81, 8, 0, 0, 16, 1'b1, "R8");
        put_byte(8'h42);
        fork
            expect_frame(8'h42, 8, 0, 0, 16, 1'b1, "R8 completes");
            begin
                wait_low();
                repeat (20) @(negedge clk);
                cts_n = 1'b1;
            end
        join
        put_byte(8'h24);
        hold_idle(200, "R8 gated again");
        cts_n = 1'b0;
        expect_frame(8'h24, 8, 0, 0, 16, 1'b1, "R8");

        // R9: software handshake
        cts_n = 1'b1;
        cfg_write(2'd0, fmtw(3, 0, 0, 2));
        rx_pulse(8'h13);
        put_byte(8'h99);
        hold_idle(200, "R9 paused");
        rx_pulse(8'h41);
        hold_idle(200, "R9 other code");
        rx_pulse(8'h11);
        expect_frame(8'h99, 8, 0, 0, 16, 1'b1, "R9");
        rx_pulse(8'h13);
        cfg_write(2'd0, fmtw(3, 0, 0, 0));
        put_byte(8'h55);
        expect_frame(8'h55, 8, 0, 0, 16, 1'b1, "R9 mode off");
        cfg_write(2'd0, fmtw(3, 0, 0, 2));
        put_byte(8'hAA);
        hold_idle(150, "R9 still paused");
        rx_pulse(8'h11);
        expect_frame(8'hAA, 8, 0, 0, 16, 1'b1, "R9");
        cts_n = 1'b0;

        // R7: break waits for the character, then holds the line low
        cfg_write(2'd0, fmtw(3, 0, 0, 0));
        put_byte(8'hF0);
        fork
            expect_frame(8'hF0, 8, 0, 0, 16, 1'b0, "R7 char finishes");
            begin
                wait_low();
                repeat (30) @(negedge clk);
                cfg_write(2'd2, 16'd1);
            end
        join
        repeat (16) @(negedge clk);
        begin
            int low_bad = 0;
            int rdy_bad = 0;
            for (int i = 0; i < 200; i++) begin
                @(negedge clk);
                if (txd !== 1'b0) low_bad++;
                if (in_ready !== 1'b0) rdy_bad++;
            end
            chk(low_bad == 0, "R7 line low", low_bad, 0);
            chk(rdy_bad == 0, "R7 not ready", rdy_bad, 0);
        end
        cfg_write(2'd2, 16'd0);
        repeat (3) @(negedge clk);
        chk(txd === 1'b1, "R7 release txd", int'(txd), 1);
        chk(in_ready === 1'b1, "R7 release ready", int'(in_ready), 1);
        cfg_write(2'd2, 16'd1);
        repeat (2) @(negedge clk);
        chk(txd === 1'b0, "R7 idle break", int'(txd), 0);
        cfg_write(2'd2, 16'd0);
        repeat (3) @(negedge clk);
        put_byte(8'h0F);
        expect_frame(8'h0F, 8, 0, 0, 16, 1'b1, "R2 after break");

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule